// File: doc/BRIEF.md
# Multiplexed Bus Slave Port

This block is the target side of a synchronous backplane bus on which address and data share one set of lines. A master opens a transfer by raising a start strobe for one cycle. In that cycle it places an address and a word count on the shared lines and an operation code on the operation lines. If the address falls inside this slave's window, the slave carries out a single or block read or write on a small internal word store. It closes the transfer by raising finish and driving a status or beat code onto the operation lines.

The bus is modelled with separate inbound and outbound lines plus drive enables, not true tri-state. Inputs are driven on the falling edge and sampled on the rising edge. A runtime input sets how many wait states the slave inserts before it answers. Every read leaves the shared lines undriven for one turnaround cycle after the start cycle. In block transfers the slave steps through consecutive store addresses itself.

Top module: `mbus_slave`

## Requirements
- R1: A start whose address (bits 7:0 of the shared lines) lies in [BASE, BASE+DEPTH) is served. Any other address gives no finish, no drive on either set of lines and no change to the store.
- R2: In the start cycle, bits 15:8 of the shared lines carry the word count. The operation codes are 1 single read, 2 single write, 3 block read, 4 block write, 5 continue and 6 hold.
- R3: On a single write, the word on the shared lines in the cycle after start is stored. Finish is then high for exactly one cycle, in cycle 2+W counted from start, with status OK (code 1) on the operation lines.
- R4: On a single read, the shared lines are not driven in the cycle after start. The stored word appears together with finish and status OK (1) in cycle 2+W.
- R5: W is the value of the wait-state input. Each wait state delays finish, and on reads the first data beat, by exactly one cycle.
- R6: On a block write, each cycle with continue (5) on the operation lines stores one word at A, A+1, and so on. Other cycles are stalls that store nothing. Finish with OK comes W+1 cycles after the last beat.
- R7: On a block read of N words, after the turnaround cycle and W wait states, the words from A to A+N-1 are driven in N consecutive cycles. The operation lines carry continue (5) on every beat but the last, and hold (6) on the last beat, which is also the only one with finish high.
- R8: An operation code other than 1 to 4, or a block transfer with a count of zero, ends with finish and status failure (2) in cycle 2+W, and the store is left unchanged.
- R9: A block transfer whose last word would lie past the top of the window ends with finish and status retry (3) in cycle 2+W, and the store is left unchanged.
- R10: A start that arrives while a transfer is in progress is ignored.
- R11: Reset clears the store to zero and drops finish and both drive enables, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start strobe from the master |
| bus_ad_in | input | ADDR_W+CNT_W | Shared address/count/data lines as driven by the master |
| bus_op_in | input | 3 | Operation or beat code from the master |
| wait_states | input | WAIT_W | Number of wait states to insert |
| bus_finish | output | 1 | Finish strobe from the slave |
| bus_ad_out | output | ADDR_W+CNT_W | Read data driven by the slave |
| bus_ad_oe | output | 1 | Slave drives the shared lines |
| bus_op_out | output | 3 | Status or beat code from the slave |
| bus_op_oe | output | 1 | Slave drives the operation lines |

## Verification
A wrong phase or wait count shows up within a single transfer as a finish pulse in the wrong cycle, a missing pulse, or a second pulse. The bench compares the finish and drive-enable pins against an expected cycle on every cycle of every transfer. A wrong block pointer shows up on the next read of the affected words as a data mismatch. This read can be a later block read that crosses the words written earlier, which also exposes stores that should have been suppressed by failure, retry, an address miss or a start during a busy transfer. A wrong beat count appears as a hold code, or the lack of one, on the wrong beat of a block read.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OPC_NONE = 3'd0,
        OPC_RD   = 3'd1,
        OPC_WR   = 3'd2,
        OPC_RBLK = 3'd3,
        OPC_WBLK = 3'd4,
        OPC_CONT = 3'd5,
        OPC_HOLD = 3'd6,
        OPC_RSVD = 3'd7
    } opc_e;

    typedef enum logic [OPW-1:0] {
        STS_NONE  = 3'd0,
        STS_OK    = 3'd1,
        STS_FAIL  = 3'd2,
        STS_RETRY = 3'd3
    } sts_e;

    typedef enum logic [2:0] {
        KIND_RD,
        KIND_WR,
        KIND_RBLK,
        KIND_WBLK,
        KIND_ERR
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_WBEAT,
        PH_WAIT,
        PH_RBEAT,
        PH_FIN
    } phase_e;

    typedef struct packed {
        kind_e kind;
        sts_e  sts;
    } class_t;

    // Sort an accepted request into a transfer kind and its closing status.
    function automatic class_t classify(input logic [OPW-1:0] op,
                                        input logic cnt_zero,
                                        input logic past_end);
        class_t c;
        c.kind = KIND_ERR;
        c.sts  = STS_FAIL;
        case (op)
            OPC_RD: begin c.kind = KIND_RD; c.sts = STS_OK; end
            OPC_WR: begin c.kind = KIND_WR; c.sts = STS_OK; end
            OPC_RBLK, OPC_WBLK: begin
                if (cnt_zero) begin
                    c.kind = KIND_ERR; c.sts = STS_FAIL;
                end else if (past_end) begin
                    c.kind = KIND_ERR; c.sts = STS_RETRY;
                end else begin
                    c.kind = (op == OPC_RBLK) ? KIND_RBLK : KIND_WBLK;
                    c.sts  = STS_OK;
                end
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic reads_back(input kind_e k);
        return (k == KIND_RD) || (k == KIND_RBLK);
    endfunction

    function automatic logic is_block(input kind_e k);
        return (k == KIND_RBLK) || (k == KIND_WBLK);
    endfunction

endpackage

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              CNT_W  = 8,
    parameter int              DEPTH  = 16,
    parameter logic [ADDR_W-1:0] BASE = 8'h40,
    parameter int              IDX_W  = $clog2(DEPTH)
) (
    input  logic [ADDR_W+CNT_W-1:0] ad,
    input  logic [OPW-1:0]          op,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic [CNT_W-1:0]        cnt,
    output class_t                  cls
);
    localparam int SPAN_W = CNT_W + 1;

    logic [ADDR_W-1:0] addr;
    logic [SPAN_W-1:0] span;
    logic              past_end;

    assign addr     = ad[ADDR_W-1:0];
    assign cnt      = ad[ADDR_W +: CNT_W];
    assign idx      = addr[IDX_W-1:0];
    assign hit      = (addr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);
    assign span     = {1'b0, cnt} + SPAN_W'(idx);
    assign past_end = (span > SPAN_W'(DEPTH));
    assign cls      = classify(op, (cnt == '0), past_end);

endmodule

// File: rtl/mbus_waitgen.sv
module mbus_waitgen #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              busy,
    output logic              last
);
    logic [WAIT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (load) begin
            wcnt <= load_val;
        end else if (wcnt != '0) begin
            wcnt <= wcnt - WAIT_W'(1);
        end
    end

    assign busy = (wcnt != '0);
    assign last = (wcnt == WAIT_W'(1));

    // R5: the final wait cycle is followed by an idle counter
    assert_wait_expires_R5: assert property (@(posedge clk) disable iff (rst)
        (last && !load) |=> !busy);

    // R5: a nonzero load always opens a wait window
    assert_wait_loaded_R5: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> busy);

endmodule

// File: rtl/mbus_store.sv
module mbus_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                CNT_W  = 8,
    parameter int                DEPTH  = 16,
    parameter logic [ADDR_W-1:0] BASE   = 8'h40,
    parameter int                WAIT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_start,
    input  logic [ADDR_W+CNT_W-1:0] bus_ad_in,
    input  logic [2:0]              bus_op_in,
    input  logic [WAIT_W-1:0]       wait_states,
    output logic                    bus_finish,
    output logic [ADDR_W+CNT_W-1:0] bus_ad_out,
    output logic                    bus_ad_oe,
    output logic [2:0]              bus_op_out,
    output logic                    bus_op_oe
);
    localparam int DATA_W = ADDR_W + CNT_W;
    localparam int IDX_W  = $clog2(DEPTH);

    phase_e            phase;
    kind_e             kind_q;
    sts_e              sts_q;
    logic [IDX_W-1:0]  ptr;
    logic [CNT_W-1:0]  remain;

    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    logic [CNT_W-1:0]  dec_cnt;
    class_t            dec_cls;

    logic              accept;
    logic              beat_in;
    logic              last_beat;
    logic              enter_tail;
    logic              wait_load;
    logic              wait_busy;
    logic              wait_last;
    logic              store_we;
    logic [DATA_W-1:0] store_rdata;
    phase_e            tail_tgt;

    mbus_decode #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH),
        .BASE   (BASE),
        .IDX_W  (IDX_W)
    ) decode_i (
        .ad  (bus_ad_in),
        .op  (bus_op_in),
        .hit (dec_hit),
        .idx (dec_idx),
        .cnt (dec_cnt),
        .cls (dec_cls)
    );

    assign accept     = bus_start && dec_hit && (phase == PH_IDLE);
    assign beat_in    = (phase == PH_WBEAT) && (bus_op_in == OPC_CONT);
    assign last_beat  = (remain == CNT_W'(1));
    assign enter_tail = (phase == PH_TURN) || (beat_in && last_beat);
    assign wait_load  = enter_tail && (wait_states != '0);
    assign tail_tgt   = reads_back(kind_q) ? PH_RBEAT : PH_FIN;
    assign store_we   = ((phase == PH_TURN) && (kind_q == KIND_WR)) || beat_in;

    mbus_waitgen #(
        .WAIT_W (WAIT_W)
    ) waitgen_i (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_states),
        .busy     (wait_busy),
        .last     (wait_last)
    );

    mbus_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W)
    ) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .waddr (ptr),
        .wdata (bus_ad_in),
        .raddr (ptr),
        .rdata (store_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            kind_q <= KIND_RD;
            sts_q  <= STS_NONE;
            ptr    <= '0;
            remain <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        kind_q <= dec_cls.kind;
                        sts_q  <= dec_cls.sts;
                        ptr    <= dec_idx;
                        remain <= is_block(dec_cls.kind) ? dec_cnt : CNT_W'(1);
                        phase  <= (dec_cls.kind == KIND_WBLK) ? PH_WBEAT : PH_TURN;
                    end
                end
                PH_TURN: begin
                    phase <= wait_load ? PH_WAIT : tail_tgt;
                end
                PH_WBEAT: begin
                    if (beat_in) begin
                        ptr    <= ptr + IDX_W'(1);
                        remain <= remain - CNT_W'(1);
                        if (last_beat) begin
                            phase <= wait_load ? PH_WAIT : tail_tgt;
                        end
                    end
                end
                PH_WAIT: begin
                    if (wait_last) begin
                        phase <= tail_tgt;
                    end
                end
                PH_RBEAT: begin
                    ptr    <= ptr + IDX_W'(1);
                    remain <= remain - CNT_W'(1);
                    if (last_beat) begin
                        phase <= PH_IDLE;
                    end
                end
                PH_FIN: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_finish = (phase == PH_FIN) || ((phase == PH_RBEAT) && last_beat);
        bus_ad_oe  = (phase == PH_RBEAT);
        bus_ad_out = bus_ad_oe ? store_rdata : '0;
        bus_op_oe  = bus_finish || bus_ad_oe;
        bus_op_out = OPC_NONE;
        if (phase == PH_FIN) begin
            bus_op_out = sts_q;
        end else if (phase == PH_RBEAT) begin
            if (!last_beat) begin
                bus_op_out = OPC_CONT;
            end else begin
                bus_op_out = (kind_q == KIND_RBLK) ? OPC_HOLD : STS_OK;
            end
        end
    end

    // R4: the cycle after an accepted start never carries slave data
    assert_turnaround_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> !bus_ad_oe);

    // R1: a start outside the window draws no response
    assert_miss_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && bus_start && !dec_hit) |=> (!bus_finish && !bus_op_oe && !bus_ad_oe));

    // R3: finish is a single-cycle pulse
    assert_finish_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        bus_finish |=> !bus_finish);

    // R7: block read beats are back to back until the closing beat
    assert_beats_contiguous_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_ad_oe && !bus_finish) |=> bus_ad_oe);

    // R5: a wait phase is only held while the counter is running
    assert_wait_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> wait_busy);

endmodule

// File: tb/mbus_slave_tb_top.sv
module mbus_slave_tb_top;
    import mbus_pkg::*;

    localparam int         ADDR_W = 8;
    localparam int         CNT_W  = 8;
    localparam int         DEPTH  = 16;
    localparam int         WAIT_W = 4;
    localparam int         DATA_W = ADDR_W + CNT_W;
    localparam logic [7:0] BASE   = 8'h40;
    localparam int         NVEC   = 17;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [7:0]  cnt;
        logic [3:0]  wt;
        logic [15:0] seed;
        logic        gap;
        logic        intr;
    } vec_t;

    // op, addr, count, wait, data seed, stall beat, start while busy
    localparam vec_t VECS [NVEC] = '{
        '{3'd2, 8'h43, 8'd0, 4'd0, 16'h1234, 1'b0, 1'b0},  // R3 write
        '{3'd1, 8'h43, 8'd0, 4'd0, 16'h0000, 1'b0, 1'b0},  // R4 read back
        '{3'd2, 8'h45, 8'd0, 4'd3, 16'hBEEF, 1'b0, 1'b1},  // R5 R10 busy start
        '{3'd1, 8'h46, 8'd0, 4'd2, 16'h0000, 1'b0, 1'b0},  // R10 busy start stored nothing
        '{3'd1, 8'h45, 8'd0, 4'd5, 16'h0000, 1'b0, 1'b0},  // R5 long wait
        '{3'd4, 8'h48, 8'd4, 4'd1, 16'hA000, 1'b1, 1'b0},  // R6 with stall
        '{3'd3, 8'h48, 8'd4, 4'd0, 16'h0000, 1'b0, 1'b0},  // R7
        '{3'd3, 8'h43, 8'd3, 4'd2, 16'h0000, 1'b0, 1'b0},  // R7 R5
        '{3'd1, 8'h30, 8'd0, 4'd0, 16'h0000, 1'b0, 1'b0},  // R1 miss below
        '{3'd2, 8'h50, 8'd0, 4'd0, 16'h7777, 1'b0, 1'b0},  // R1 miss above
        '{3'd7, 8'h41, 8'd0, 4'd1, 16'h0000, 1'b0, 1'b0},  // R8 bad op
        '{3'd3, 8'h41, 8'd0, 4'd0, 16'h0000, 1'b0, 1'b0},  // R8 zero count
        '{3'd4, 8'h4E, 8'd3, 4'd2, 16'h5555, 1'b0, 1'b0},  // R9 crosses top
        '{3'd3, 8'h4D, 8'd3, 4'd0, 16'h0000, 1'b0, 1'b0},  // R9 nothing stored, R7 at top edge
        '{3'd4, 8'h4F, 8'd1, 4'd0, 16'h0F0F, 1'b0, 1'b0},  // R6 single beat at top
        '{3'd1, 8'h4F, 8'd0, 4'd0, 16'h0000, 1'b0, 1'b0},  // R4
        '{3'd5, 8'h40, 8'd0, 4'd0, 16'h0000, 1'b0, 1'b0}   // R8 beat code as op
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    bus_start = 1'b0;
    logic [DATA_W-1:0]       bus_ad_in = '0;
    logic [2:0]              bus_op_in = '0;
    logic [WAIT_W-1:0]       wait_states = '0;
    logic                    bus_finish;
    logic [DATA_W-1:0]       bus_ad_out;
    logic                    bus_ad_oe;
    logic [2:0]              bus_op_out;
    logic                    bus_op_oe;

    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    logic [15:0] model [DEPTH];

    always #4 clk = ~clk;

    mbus_slave #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH),
        .BASE   (BASE),
        .WAIT_W (WAIT_W)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_start   (bus_start),
        .bus_ad_in   (bus_ad_in),
        .bus_op_in   (bus_op_in),
        .wait_states (wait_states),
        .bus_finish  (bus_finish),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_op_out  (bus_op_out),
        .bus_op_oe   (bus_op_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int          k;
        int          idx;
        int          cnt;
        int          wt;
        int          last_in;
        int          fin_at;
        int          n_end;
        int          b;
        logic        hit;
        logic        exp_fin;
        logic        exp_oe;
        logic [2:0]  exp_op;
        string       tag;
        hit = (v.addr[7:4] == BASE[7:4]);
        idx = int'(v.addr[3:0]);
        cnt = int'(v.cnt);
        wt  = int'(v.wt);
        // 0 miss, 1 read, 2 write, 3 block read, 4 block write, 5 fail, 6 retry
        if (!hit) k = 0;
        else begin
            case (v.op)
                3'd1: k = 1;
                3'd2: k = 2;
                3'd3, 3'd4: begin
                    if (cnt == 0) k = 5;
                    else if (idx + cnt > DEPTH) k = 6;
                    else k = (v.op == 3'd3) ? 3 : 4;
                end
                default: k = 5;
            endcase
        end
        last_in = cnt + ((v.gap && cnt > 1) ? 1 : 0);
        case (k)
            0: begin fin_at = -1;               tag = "R1";    end
            1: begin fin_at = 2 + wt;           tag = "R4 R5"; end
            2: begin fin_at = 2 + wt;           tag = "R3 R5"; end
            3: begin fin_at = 1 + wt + cnt;     tag = "R7 R2"; end
            4: begin fin_at = last_in + 1 + wt; tag = "R6 R2"; end
            5: begin fin_at = 2 + wt;           tag = "R8";    end
            default: begin fin_at = 2 + wt;     tag = "R9";    end
        endcase
        n_end = (k == 0) ? 12 : fin_at + 2;

        @(negedge clk);
        bus_start   = 1'b1;
        bus_ad_in   = {v.cnt, v.addr};
        bus_op_in   = v.op;
        wait_states = v.wt;
        for (int n = 1; n <= n_end; n++) begin
            @(negedge clk);
            exp_fin = (n == fin_at);
            exp_oe  = ((k == 1) && (n == fin_at)) || ((k == 3) && (n >= 2 + wt) && (n <= fin_at));
            chk(tag, "finish/ad_oe/op_oe",
                {13'b0, bus_finish, bus_ad_oe, bus_op_oe},
                {13'b0, exp_fin, exp_oe, exp_fin | exp_oe});
            if (exp_oe) begin
                chk(tag, "read data", bus_ad_out, model[idx + (n - (2 + wt))]);
            end
            if (exp_oe || exp_fin) begin
                if (k == 3) exp_op = (n == fin_at) ? 3'd6 : 3'd5;
                else if (k == 5) exp_op = 3'd2;
                else if (k == 6) exp_op = 3'd3;
                else exp_op = 3'd1;
                chk(tag, "op lines", {13'b0, bus_op_out}, {13'b0, exp_op});
            end
            bus_start = 1'b0;
            bus_op_in = 3'd0;
            bus_ad_in = 16'hFFFF;
            if (v.op == 3'd2 && n == 1) bus_ad_in = v.seed;
            if (v.op == 3'd4) begin
                if (v.gap && n == 2) b = -1;
                else b = (v.gap && n > 2) ? n - 2 : n - 1;
                if (b >= 0 && b < cnt) begin
                    bus_ad_in = v.seed + 16'(b);
                    bus_op_in = 3'd5;
                end
            end
            // R10: a second start to word 6 while the slave is busy
            if (v.intr && n == 2) begin
                bus_start = 1'b1;
                bus_op_in = 3'd2;
                bus_ad_in = {8'h00, BASE | 8'h06};
            end
            if (v.intr && n == 3) bus_ad_in = 16'hDEAD;
        end
        if (k == 2) model[idx] = v.seed;
        if (k == 4) begin
            for (int j = 0; j < cnt; j++) model[idx + j] = v.seed + 16'(j);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R11: outputs quiet under reset
        chk("R11", "finish/ad_oe/op_oe in reset",
            {13'b0, bus_finish, bus_ad_oe, bus_op_oe}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "finish/ad_oe/op_oe after reset",
            {13'b0, bus_finish, bus_ad_oe, bus_op_oe}, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R11: reset in the middle of a read with a long wait
        @(negedge clk);
        bus_start   = 1'b1;
        bus_ad_in   = {8'd0, 8'h43};
        bus_op_in   = 3'd1;
        wait_states = 4'd5;
        @(negedge clk);
        bus_start = 1'b0;
        bus_op_in = 3'd0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "finish/ad_oe/op_oe after mid reset",
            {13'b0, bus_finish, bus_ad_oe, bus_op_oe}, 16'h0000);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            chk("R11", "no stale finish after reset",
                {15'b0, bus_finish}, 16'h0000);
        end
        // R11: store was cleared, so the earlier word reads back as zero
        run_vec('{3'd1, 8'h43, 8'd0, 4'd0, 16'h0000, 1'b0, 1'b0});
        run_vec('{3'd3, 8'h48, 8'd4, 4'd1, 16'h0000, 1'b0, 1'b0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule